// File: doc/BRIEF.md
# Multiply-Divide Execution Unit with Stack Writeback

This execution unit serves an 8-bit accumulator CPU. It computes an unsigned 8x8 product or an unsigned 16-by-8 quotient. The CPU has no register wide enough to hold a second result byte, so the unit returns one byte through the accumulator write port. The other byte goes out through a stack-push port, together with a strobe that tells the stack pointer to step down.

For a multiply, the accumulator value is multiplied by a memory operand. The low product byte returns to the accumulator and the high product byte is pushed. For a divide, a 16-bit dividend arrives on its own input and the accumulator supplies the divisor. The quotient byte returns to the accumulator and the two's-complement negation of the remainder is pushed.

Both operations take a fixed number of cycles. While an operation runs, the unit ignores further start requests. A divisor of zero raises an error flag and suppresses every write. A quotient too large for one byte raises an overflow flag.

Top module: `mdstk_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy_o`, `acc_we_o`, `push_vld_o`, `sp_dec_o`, `dz_err_o` and `ovf_o` are all 0.
- R2: With `op_i` = 0 (multiply), `acc_wd_o` carries bits 7:0 of the unsigned product `acc_i * mem_i`, using the operand values sampled at the accepting edge.
- R3: For a multiply, `push_data_o` carries bits 15:8 of that product.
- R4: With `op_i` = 1 (divide) and a nonzero `acc_i`, `acc_wd_o` carries bits 7:0 of the unsigned quotient `dvd_i / acc_i`.
- R5: For a nonzero divisor, `push_data_o` carries (256 - remainder) mod 256, where the remainder is `dvd_i % acc_i`.
- R6: A start is accepted on a rising edge at which `start_i` is high and `busy_o` is low. `busy_o` goes high at that edge and goes low 10 edges later. `acc_we_o` and `push_vld_o` are high together for exactly one cycle, beginning 9 edges after the accepting edge, and are never high apart.
- R7: `sp_dec_o` is a one-cycle pulse in the cycle that immediately follows each push cycle. It is never high at any other time.
- R8: For a divide with `acc_i` = 0, `dz_err_o` goes high at the writeback edge, and `acc_we_o`, `push_vld_o` and `sp_dec_o` stay low for that operation.
- R9: At the writeback edge of a divide, `ovf_o` goes high exactly when the true quotient exceeds 255; the written quotient is then its low 8 bits. A multiply never sets `ovf_o`.
- R10: A `start_i` pulse while `busy_o` is high has no effect: it produces no extra result, and the running operation completes with its own operands and timing.
- R11: `dz_err_o` and `ovf_o` clear at the edge that accepts a start. Between operations they hold the values set at the last writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| acc_i | input | 8 | Accumulator value: multiplier, or divisor for a divide |
| mem_i | input | 8 | Memory operand for a multiply |
| dvd_i | input | 16 | Dividend for a divide |
| busy_o | output | 1 | High while an operation is in flight |
| acc_we_o | output | 1 | Accumulator write strobe |
| acc_wd_o | output | 8 | Accumulator write data |
| push_vld_o | output | 1 | Stack push strobe |
| push_data_o | output | 8 | Stack push data |
| sp_dec_o | output | 1 | Stack pointer decrement strobe |
| dz_err_o | output | 1 | Divide-by-zero flag |
| ovf_o | output | 1 | Quotient overflow flag |

## Verification
Two pairs of events share a cycle. The accumulator write and the push always coincide. A start issued the moment `busy_o` falls is accepted in the same cycle as the previous operation's stack-pointer decrement. The bench provokes the second overlap by issuing operations back to back: its driver waits only for `busy_o` to fall and then raises `start_i` at once. The scoreboard monitor judges both overlaps. It checks the write strobe, the push strobe and both data bytes together in the predicted cycle, and it checks the decrement pulse in the next cycle, even while a new operation has already started.

// File: rtl/mdstk_pkg.sv
package mdstk_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2,
    ST_SPD  = 2'd3
  } st_e;
endpackage

// File: rtl/mdstk_seq.sv
module mdstk_seq #(
  parameter int ITER = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic wb_o,
  output logic spd_o,
  output logic busy_o
);
  import mdstk_pkg::*;
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_RUN);
  assign wb_o   = (st_q == ST_WB);
  assign spd_o  = (st_q == ST_SPD);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_WB;
        end
        ST_WB:  st_q <= ST_SPD;
        ST_SPD: begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the iteration count advances by one each RUN cycle, or leaves RUN for writeback
  assert_run_progress_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |=> ((st_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1) || st_q == ST_WB));

  // R10: no state other than IDLE lets a start through
  assert_busy_matches_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN || st_q == ST_WB) |-> busy_q);
endmodule

// File: rtl/mdstk_mul.sv
module mdstk_mul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W + 1;

  logic [W-1:0]  mc_q;
  logic [PW-1:0] p_q;
  logic [W:0]    sum;
  logic [PW-1:0] p_next;

  always_comb begin
    sum    = p_q[PW-1:W] + (p_q[0] ? {1'b0, mc_q} : '0);
    p_next = {sum, p_q[W-1:0]} >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
      p_q  <= '0;
    end else if (load_i) begin
      mc_q <= mcand_i;
      p_q  <= {{(W+1){1'b0}}, mplier_i};
    end else if (step_i) begin
      p_q <= p_next;
    end
  end

  assign prod_o = p_q[2*W-1:0];

  // R2: the product register never uses its guard bit once a shift has completed
  assert_guard_clear_R2: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (p_q[PW-1] == 1'b0));
endmodule

// File: rtl/mdstk_div.sv
module mdstk_div #(
  parameter int W    = 8,
  parameter int ITER = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  localparam int SPC = (2 * W + ITER - 1) / ITER;

  logic [W-1:0]   dvs_q;
  logic [W-1:0]   rem_q;
  logic [2*W-1:0] q_q;

  logic [W-1:0]   r_s [SPC+1];
  logic [2*W-1:0] q_s [SPC+1];

  assign r_s[0] = rem_q;
  assign q_s[0] = q_q;

  for (genvar k = 0; k < SPC; k++) begin : g_stage
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    always_comb begin
      trial = {r_s[k], q_s[k][2*W-1]};
      diff  = trial - {1'b0, dvs_q};
      fits  = (trial >= {1'b0, dvs_q});
    end
    assign r_s[k+1] = fits ? diff[W-1:0] : trial[W-1:0];
    assign q_s[k+1] = {q_s[k][2*W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
    end else if (load_i) begin
      dvs_q <= dvs_i;
      rem_q <= '0;
      q_q   <= dvd_i;
    end else if (step_i) begin
      rem_q <= r_s[SPC];
      q_q   <= q_s[SPC];
    end
  end

  assign quo_o = q_q;
  assign rem_o = rem_q;

  // R5: the partial remainder stays below a nonzero divisor
  assert_rem_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/mdstk_unit.sv
module mdstk_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   mem_i,
  input  logic [2*W-1:0] dvd_i,
  output logic           busy_o,
  output logic           acc_we_o,
  output logic [W-1:0]   acc_wd_o,
  output logic           push_vld_o,
  output logic [W-1:0]   push_data_o,
  output logic           sp_dec_o,
  output logic           dz_err_o,
  output logic           ovf_o
);
  import mdstk_pkg::*;
  localparam int ITER = W;

  logic           load, step, wb, spd;
  logic [2*W-1:0] prod, quo;
  logic [W-1:0]   rem;
  op_e            op_q;
  logic           dz_q;

  mdstk_seq #(.ITER(ITER)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .step_o(step), .wb_o(wb), .spd_o(spd), .busy_o(busy_o)
  );

  mdstk_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .mcand_i(mem_i), .mplier_i(acc_i), .prod_o(prod)
  );

  mdstk_div #(.W(W), .ITER(ITER)) u_div (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .dvd_i(dvd_i), .dvs_i(acc_i), .quo_o(quo), .rem_o(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= OP_MUL;
      dz_q        <= 1'b0;
      acc_we_o    <= 1'b0;
      acc_wd_o    <= '0;
      push_vld_o  <= 1'b0;
      push_data_o <= '0;
      sp_dec_o    <= 1'b0;
      dz_err_o    <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      acc_we_o   <= 1'b0;
      push_vld_o <= 1'b0;
      sp_dec_o   <= spd && !dz_q;
      if (load) begin
        op_q     <= op_e'(op_i);
        dz_q     <= (op_e'(op_i) == OP_DIV) && (acc_i == '0);
        dz_err_o <= 1'b0;
        ovf_o    <= 1'b0;
      end
      if (wb) begin
        if (op_q == OP_MUL) begin
          acc_we_o    <= 1'b1;
          push_vld_o  <= 1'b1;
          acc_wd_o    <= prod[W-1:0];
          push_data_o <= prod[2*W-1:W];
        end else if (dz_q) begin
          dz_err_o <= 1'b1;
        end else begin
          acc_we_o    <= 1'b1;
          push_vld_o  <= 1'b1;
          acc_wd_o    <= quo[W-1:0];
          push_data_o <= W'(0) - rem;
          ovf_o       <= |quo[2*W-1:W];
        end
      end
    end
  end

  // R6: accumulator write and push always coincide
  assert_write_push_pair_R6: assert property (@(posedge clk) disable iff (rst)
    acc_we_o == push_vld_o);

  // R6: results only appear while busy
  assert_write_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    acc_we_o |-> busy_o);

  // R7: decrement follows each push by exactly one cycle
  assert_dec_after_push_R7: assert property (@(posedge clk) disable iff (rst)
    push_vld_o |=> sp_dec_o);
  assert_dec_only_after_push_R7: assert property (@(posedge clk) disable iff (rst)
    sp_dec_o |-> $past(push_vld_o));

  // R8: a zero divisor blocks the writes
  assert_dz_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    dz_err_o |-> !acc_we_o && !push_vld_o);

  // R9: overflow never reported for a multiply
  assert_mul_no_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_we_o && op_q == OP_MUL) |-> !ovf_o);
endmodule

// File: tb/mdstk_unit_bench.sv
module mdstk_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  mem_i = '0;
  logic [15:0] dvd_i = '0;
  logic        busy_o, acc_we_o, push_vld_o, sp_dec_o, dz_err_o, ovf_o;
  logic [7:0]  acc_wd_o, push_data_o;

  mdstk_unit u_mdstk_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .acc_i(acc_i),
    .mem_i(mem_i), .dvd_i(dvd_i), .busy_o(busy_o), .acc_we_o(acc_we_o),
    .acc_wd_o(acc_wd_o), .push_vld_o(push_vld_o), .push_data_o(push_data_o),
    .sp_dec_o(sp_dec_o), .dz_err_o(dz_err_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] push;
    logic       dz;
    logic       ovf;
    int         when;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nerr = 0;
  int   sp_cyc = -1;
  logic sp_exp = 1'b0;
  logic last_dz = 1'b0;
  logic last_ovf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // monitor: pops expectations in the predicted cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && cyc == q[0].when) begin
        exp_t e;
        e = q.pop_front();
        chk(acc_we_o == !e.dz, "R6", {e.tag, " acc_we"}, acc_we_o, !e.dz);
        chk(push_vld_o == !e.dz, "R6", {e.tag, " push_vld"}, push_vld_o, !e.dz);
        chk(busy_o == 1'b1, "R6", {e.tag, " busy at writeback"}, busy_o, 1);
        if (!e.dz) begin
          chk(acc_wd_o == e.acc, "R2/R4", {e.tag, " acc data"}, acc_wd_o, e.acc);
          chk(push_data_o == e.push, "R3/R5", {e.tag, " push data"}, push_data_o, e.push);
        end
        chk(dz_err_o == e.dz, "R8", {e.tag, " dz flag"}, dz_err_o, e.dz);
        chk(ovf_o == e.ovf, "R9", {e.tag, " ovf flag"}, ovf_o, e.ovf);
        sp_cyc = cyc + 1;
        sp_exp = !e.dz;
      end else if (acc_we_o || push_vld_o) begin
        chk(1'b0, "R10", "unexpected write", {acc_we_o, push_vld_o}, 0);
      end
      if (cyc == sp_cyc) begin
        chk(sp_dec_o == sp_exp, "R7", "sp_dec pulse", sp_dec_o, sp_exp);
        chk(busy_o == 1'b0, "R6", "busy fall", busy_o, 0);
      end else if (sp_dec_o) begin
        chk(1'b0, "R7", "stray sp_dec", sp_dec_o, 0);
      end
    end
  end

  task automatic issue(input logic op, input logic [7:0] a, input logic [7:0] m,
                       input logic [15:0] d, input string tag);
    exp_t e;
    logic [15:0] p;
    logic [15:0] qt;
    logic [7:0]  r;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chk(dz_err_o == last_dz, "R11", {tag, " dz held"}, dz_err_o, last_dz);
    chk(ovf_o == last_ovf, "R11", {tag, " ovf held"}, ovf_o, last_ovf);
    start_i = 1'b1; op_i = op; acc_i = a; mem_i = m; dvd_i = d;
    @(posedge clk);
    #1;
    start_i = 1'b0;
    e.tag = tag;
    e.when = cyc + 9;
    if (op == 1'b0) begin
      p = 16'(a) * 16'(m);
      e.acc = p[7:0]; e.push = p[15:8]; e.dz = 1'b0; e.ovf = 1'b0;
    end else if (a == 8'd0) begin
      e.acc = 8'h00; e.push = 8'h00; e.dz = 1'b1; e.ovf = 1'b0;
    end else begin
      qt = d / 16'(a);
      r  = 8'(d % 16'(a));
      e.acc = qt[7:0]; e.push = 8'(9'd256 - 9'(r)); e.dz = 1'b0; e.ovf = (qt > 16'd255);
    end
    q.push_back(e);
    last_dz = e.dz;
    last_ovf = e.ovf;
    @(negedge clk);
    chk(busy_o == 1'b1, "R6", {tag, " busy rise"}, busy_o, 1);
    chk(dz_err_o == 1'b0 && ovf_o == 1'b0, "R11", {tag, " flags cleared"},
        {dz_err_o, ovf_o}, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && acc_we_o == 0 && push_vld_o == 0 && sp_dec_o == 0 &&
        dz_err_o == 0 && ovf_o == 0, "R1", "in reset",
        {busy_o, acc_we_o, push_vld_o, sp_dec_o, dz_err_o, ovf_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && acc_we_o == 0 && push_vld_o == 0 && sp_dec_o == 0 &&
        dz_err_o == 0 && ovf_o == 0, "R1", "after reset",
        {busy_o, acc_we_o, push_vld_o, sp_dec_o, dz_err_o, ovf_o}, 0);

    issue(1'b0, 8'd12, 8'd34, 16'h0, "R2 mul 12x34");
    issue(1'b0, 8'hFF, 8'hFF, 16'h0, "R3 mul max");
    issue(1'b0, 8'h00, 8'hA5, 16'h0, "R2 mul zero");
    issue(1'b1, 8'd7, 8'h00, 16'd1000, "R4 div 1000/7");
    issue(1'b1, 8'd0, 8'h00, 16'd1234, "R8 div zero");
    issue(1'b0, 8'h80, 8'h02, 16'h0, "R11 mul after dz");
    issue(1'b1, 8'd1, 8'h00, 16'hFFFF, "R9 ovf FFFF/1");
    issue(1'b1, 8'd16, 8'h00, 16'h0FF0, "R5 zero rem");
    issue(1'b1, 8'hFF, 8'h00, 16'hFEFF, "R9 max no ovf");
    issue(1'b1, 8'hFF, 8'h00, 16'hFF00, "R9 just ovf");

    // R10: a start inside a running op is ignored
    issue(1'b0, 8'd200, 8'd3, 16'h0, "R10 running");
    repeat (2) @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; acc_i = 8'd0; mem_i = 8'h11; dvd_i = 16'h5555;
    @(negedge clk);
    start_i = 1'b0;
    issue(1'b1, 8'd9, 8'h00, 16'd500, "R10 next");

    for (int i = 0; i < 24; i++) begin
      logic [7:0] a = 8'(i * 37 + 5);
      logic [7:0] m = 8'(i * 91 + 17);
      logic [15:0] d = 16'(i * 2711 + 99);
      issue(1'(i % 2), (i % 2 == 1) ? 8'(a | 8'h01) : a, m, d,
            (i % 2 == 1) ? "R4 sweep div" : "R2 sweep mul");
    end

    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule